// File: doc/BRIEF.md
# Byte-Lane APB Write/Read Requester

This block sits between a simple local request port and a single APB4 subordinate. Each local request gives a byte address, an access size of one, two or four bytes, data packed into the low bits, and a direction flag. For a write, the block moves the data onto the byte lanes that the address selects and raises one strobe bit for each lane it fills. Only those lanes change in the subordinate, so a sub-word write needs no read-modify-write. For a read, the block drives an all-zero strobe, takes the full returned word, and hands back only the requested bytes, moved down to bit 0.

Each transfer has one SETUP cycle followed by ACCESS cycles, and ends on the first ACCESS cycle in which the subordinate signals ready. The result is returned as a one-cycle response carrying read data and the error flag. If a request crosses a word boundary or uses an illegal size, it is answered with an error in the same cycle and nothing appears on the bus. While a transfer completes, a waiting request is taken at once, so a second transfer starts with no idle cycle between them.

Top module: `subword_apb_mgr`

## Requirements
- R1: A write of size code 0 (one byte) at byte offset k = req_addr[1:0] drives pstrb = 1 << k and places req_wdata[7:0] on pwdata[8k+7:8k].
- R2: A write of size code 1 (two bytes) at offset 0 or 2 drives pstrb = 4'b0011 << offset and places req_wdata[15:0] on pwdata starting at bit 8*offset.
- R3: A write of size code 2 (four bytes) at offset 0 drives pstrb = 4'b1111 and pwdata = req_wdata.
- R4: A request is rejected if it has size code 1 at an odd offset, size code 2 at a non-zero offset, or size code 3. A rejected request gets rsp_valid and rsp_err in the cycle in which it is presented while idle, and it starts no bus transfer.
- R5: An accepted request is followed by exactly one SETUP cycle (psel=1, penable=0) and then ACCESS (psel=1, penable=1). paddr is the request address with bits [1:0] cleared. With no wait states the response comes two cycles after acceptance.
- R6: paddr, pwrite, pwdata and pstrb stay unchanged from SETUP through every ACCESS cycle. The transfer ends on the first ACCESS cycle with pready=1, after exactly (wait states + 1) ACCESS cycles.
- R7: A read drives pwrite=0 and pstrb=4'b0000. rsp_rdata holds the requested bytes of prdata shifted down by 8*offset, with all higher bytes zero.
- R8: rsp_err in the completing cycle equals pslverr. rsp_valid pulses for exactly that cycle.
- R9: req_ready is high only while idle, or in the completing ACCESS cycle when the waiting request is legal. A request taken in the completing cycle goes straight to SETUP with no idle cycle.
- R10: After reset, psel=0, penable=0, req_ready=1 and rsp_valid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Local request present |
| req_ready | output | 1 | Request taken on this edge when valid |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | 0 one byte, 1 two bytes, 2 four bytes, 3 illegal |
| req_write | input | 1 | 1 write, 0 read |
| req_wdata | input | DATA_W | Write data, low-aligned |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_rdata | output | DATA_W | Read bytes, low-aligned, zero above |
| rsp_err | output | 1 | Subordinate error or rejected request |
| psel | output | 1 | APB select |
| penable | output | 1 | APB enable (ACCESS phase) |
| pwrite | output | 1 | APB direction |
| paddr | output | ADDR_W | Word-aligned APB address |
| pwdata | output | DATA_W | Lane-placed write data |
| pstrb | output | DATA_W/8 | Per-lane write strobe |
| pready | input | 1 | Subordinate ready |
| prdata | input | DATA_W | Subordinate read word |
| pslverr | input | 1 | Subordinate error |

## Verification
The bench writes single bytes at each of the four offsets and half-words at both legal offsets. It then reads the words back and checks that the neighbouring bytes are unchanged, which catches a strobe that is shifted, zero-fills lanes, or is encoded rather than a mask. It reads bytes and half-words from the middle of a word, so an extractor that forgets to shift or to clear the upper bytes returns the wrong value. Misaligned and size-3 requests must produce a same-cycle error and no SETUP. A design that checks alignment too late would let a bus cycle escape. Wait-state and back-to-back runs show whether fields drift during ACCESS, whether the block finishes one cycle early or late, and whether it drops an idle cycle between chained transfers.

// File: rtl/subw_pkg.sv
package subw_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_ACCESS = 2'd2
    } phase_e;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;

endpackage

// File: rtl/subw_lane_map.sv
// Turns offset and size into a lane mask, moves write data onto lanes,
// and flags sizes wider than the bus or offsets not aligned to the size.
module subw_lane_map #(
    parameter int  DATA_W = 32,
    localparam int NB     = DATA_W / 8,
    localparam int OFF_W  = $clog2(NB)
) (
    input  logic [OFF_W-1:0]  off_i,
    input  logic [1:0]        size_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [NB-1:0]     strb_o,
    output logic [DATA_W-1:0] lanes_o,
    output logic              bad_o
);
    int unsigned nb_w;
    int unsigned off_w;

    always_comb begin
        nb_w  = 32'd1 << size_i;
        off_w = 32'(off_i);
        bad_o = (nb_w > 32'(NB)) || ((off_w & (nb_w - 32'd1)) != 32'd0);
    end

    for (genvar g = 0; g < NB; g++) begin : g_lane
        assign strb_o[g] = !bad_o && (32'(g) >= off_w) && (32'(g) < off_w + nb_w);
    end

    assign lanes_o = wdata_i << (off_w * 32'd8);

endmodule

// File: rtl/subw_read_align.sv
// Moves the selected bytes of a returned word down to bit 0 and clears the rest.
module subw_read_align #(
    parameter int  DATA_W = 32,
    localparam int NB     = DATA_W / 8,
    localparam int OFF_W  = $clog2(NB)
) (
    input  logic [OFF_W-1:0]  off_i,
    input  logic [1:0]        size_i,
    input  logic [DATA_W-1:0] word_i,
    output logic [DATA_W-1:0] data_o
);
    int unsigned       nb_w;
    logic [DATA_W-1:0] shifted;

    always_comb begin
        nb_w    = 32'd1 << size_i;
        shifted = word_i >> (32'(off_i) * 32'd8);
    end

    for (genvar g = 0; g < NB; g++) begin : g_byte
        assign data_o[8*g +: 8] = (32'(g) < nb_w) ? shifted[8*g +: 8] : 8'h00;
    end

endmodule

// File: rtl/subword_apb_mgr.sv
module subword_apb_mgr
    import subw_pkg::*;
#(
    parameter int  ADDR_W = 32,
    parameter int  DATA_W = 32,
    localparam int STRB_W = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_err,
    output logic              psel,
    output logic              penable,
    output logic              pwrite,
    output logic [ADDR_W-1:0] paddr,
    output logic [DATA_W-1:0] pwdata,
    output logic [STRB_W-1:0] pstrb,
    input  logic              pready,
    input  logic [DATA_W-1:0] prdata,
    input  logic              pslverr
);
    localparam int OFF_W = $clog2(STRB_W);

    typedef struct packed {
        phase_e            ph;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [STRB_W-1:0] strb;
        logic              wr;
        logic [OFF_W-1:0]  off;
        logic [1:0]        size;
    } xfer_t;

    xfer_t xfer_q, xfer_d;

    logic [STRB_W-1:0] map_strb;
    logic [DATA_W-1:0] map_lanes;
    logic              map_bad;
    logic [DATA_W-1:0] rd_aligned;
    logic              is_idle, is_done, take, reject;

    subw_lane_map #(.DATA_W(DATA_W)) u_map (
        .off_i   (req_addr[OFF_W-1:0]),
        .size_i  (req_size),
        .wdata_i (req_wdata),
        .strb_o  (map_strb),
        .lanes_o (map_lanes),
        .bad_o   (map_bad)
    );

    subw_read_align #(.DATA_W(DATA_W)) u_align (
        .off_i  (xfer_q.off),
        .size_i (xfer_q.size),
        .word_i (prdata),
        .data_o (rd_aligned)
    );

    always_comb begin
        is_idle = (xfer_q.ph == PH_IDLE);
        is_done = (xfer_q.ph == PH_ACCESS) && pready;
        take    = req_valid && !map_bad && (is_idle || is_done);
        reject  = req_valid && map_bad && is_idle;

        xfer_d = xfer_q;
        case (xfer_q.ph)
            PH_IDLE:   xfer_d.ph = PH_IDLE;
            PH_SETUP:  xfer_d.ph = PH_ACCESS;
            PH_ACCESS: if (pready) xfer_d.ph = PH_IDLE;
            default:   xfer_d.ph = PH_IDLE;
        endcase

        if (take) begin
            xfer_d.ph    = PH_SETUP;
            xfer_d.addr  = {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
            xfer_d.wr    = req_write;
            xfer_d.wdata = req_write ? map_lanes : '0;
            xfer_d.strb  = req_write ? map_strb : '0;
            xfer_d.off   = req_addr[OFF_W-1:0];
            xfer_d.size  = req_size;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) xfer_q <= '0;
        else        xfer_q <= xfer_d;
    end

    assign req_ready = is_idle || (is_done && !map_bad);
    assign rsp_valid = is_done || reject;
    assign rsp_err   = is_done ? pslverr : reject;
    assign rsp_rdata = (is_done && !xfer_q.wr) ? rd_aligned : '0;

    assign psel    = (xfer_q.ph != PH_IDLE);
    assign penable = (xfer_q.ph == PH_ACCESS);
    assign pwrite  = xfer_q.wr;
    assign paddr   = xfer_q.addr;
    assign pwdata  = xfer_q.wdata;
    assign pstrb   = xfer_q.strb;

endmodule

// File: rtl/subword_apb_mgr_chk.sv
module subword_apb_mgr_chk #(
    parameter int  ADDR_W = 32,
    parameter int  DATA_W = 32,
    localparam int STRB_W = DATA_W / 8,
    localparam int OFF_W  = $clog2(STRB_W)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic              psel,
    input logic              penable,
    input logic              pwrite,
    input logic [ADDR_W-1:0] paddr,
    input logic [DATA_W-1:0] pwdata,
    input logic [STRB_W-1:0] pstrb,
    input logic              pready
);
    // R5
    setup_then_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && !penable) |=> (psel && penable));

    // R5
    word_aligned_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        psel |-> (paddr[OFF_W-1:0] == '0));

    // R6
    fields_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && !(penable && pready)) |=>
            ($stable(paddr) && $stable(pstrb) && $stable(pwdata) && $stable(pwrite) && psel));

    // R7
    read_strobe_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && !pwrite) |-> (pstrb == '0));

    // R1
    write_strobe_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && pwrite) |-> (pstrb != '0));

    // R4
    reject_no_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err && !psel) |=> !psel);

    // R9
    ready_when_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!psel || (penable && pready)));

    // R8
    single_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && psel) |=> !(psel && penable && $stable(penable) && $past(pready) && !pready && rsp_valid));

endmodule

bind subword_apb_mgr subword_apb_mgr_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .psel      (psel),
    .penable   (penable),
    .pwrite    (pwrite),
    .paddr     (paddr),
    .pwdata    (pwdata),
    .pstrb     (pstrb),
    .pready    (pready)
);

// File: tb/subword_apb_mgr_bench.sv
`timescale 1ns/1ps
module subword_apb_mgr_bench;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        req_valid = 0, req_ready, req_write = 0;
    logic [31:0] req_addr = 0, req_wdata = 0;
    logic [1:0]  req_size = 0;
    logic        rsp_valid, rsp_err;
    logic [31:0] rsp_rdata;
    logic        psel, penable, pwrite, pready, pslverr;
    logic [31:0] paddr, pwdata, prdata;
    logic [3:0]  pstrb;

    int checks = 0, fails = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    subword_apb_mgr u_subword_apb_mgr (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
        .pwdata(pwdata), .pstrb(pstrb), .pready(pready), .prdata(prdata), .pslverr(pslverr)
    );

    // Subordinate model: 16 words, word 15 answers with an error.
    logic [31:0] mem [16];
    int          wait_n = 0;
    int          wcnt = 0;
    int          setups = 0, hold_bad = 0, acc_cyc = 0, last_acc = 0;
    logic [31:0] s_addr, s_wdata;
    logic [3:0]  s_strb;
    logic        s_wr;

    function automatic logic [31:0] init_word(int i);
        return {8'(i), 8'hC2, 8'hB1, 8'hA0};
    endfunction

    assign pready  = psel && penable && (wcnt == wait_n);
    assign prdata  = mem[paddr[5:2]];
    assign pslverr = pready && (paddr[5:2] == 4'd15);

    always @(posedge clk) begin
        if (psel && penable && !pready) wcnt <= wcnt + 1;
        else                            wcnt <= 0;
    end

    always @(negedge clk) begin
        if (psel && !penable) begin
            setups++;
            s_addr = paddr; s_strb = pstrb; s_wdata = pwdata; s_wr = pwrite;
            acc_cyc = 0;
        end
        if (psel && penable) begin
            acc_cyc++;
            if (paddr != s_addr || pstrb != s_strb || pwdata != s_wdata || pwrite != s_wr)
                hold_bad++;
            if (pready) begin
                last_acc = acc_cyc;
                if (pwrite)
                    for (int i = 0; i < 4; i++)
                        if (pstrb[i]) mem[paddr[5:2]][8*i +: 8] = pwdata[8*i +: 8];
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [31:0] a, input logic [1:0] sz, input logic wr,
                         input logic [31:0] wd, output logic [31:0] rd, output logic er,
                         output int cyc);
        bit acc = 0, took, done = 0;
        cyc = 0; rd = 0; er = 0;
        @(negedge clk);
        req_addr = a; req_size = sz; req_write = wr; req_wdata = wd; req_valid = 1;
        while (!done) begin
            #1;
            took = !acc && req_ready;
            if (took) acc = 1;
            if (acc && rsp_valid) begin
                rd = rsp_rdata; er = rsp_err; done = 1;
            end
            @(negedge clk);
            if (took) req_valid = 0;
            if (!done && acc) cyc++;
        end
    endtask

    task automatic t_reset;
        #1;
        chk(psel == 0 && penable == 0, "R10", {30'b0, psel, penable}, 0);
        chk(req_ready == 1 && rsp_valid == 0, "R10", {30'b0, req_ready, rsp_valid}, 32'h2);
    endtask

    task automatic t_byte_writes;
        logic [31:0] rd, exp; logic er; int c;
        for (int k = 0; k < 4; k++) begin
            issue(32'h8 + 32'(k), 2'd0, 1'b1, 32'hDEAD_BE00 | 32'(8'h10 + k), rd, er, c);
            chk(s_strb == 4'(1 << k), "R1", 32'(s_strb), 32'(1 << k));
            chk(s_wdata[8*k +: 8] == 8'(8'h10 + k), "R1", 32'(s_wdata[8*k +: 8]), 32'(8'h10 + k));
            chk(s_addr == 32'h8, "R5", s_addr, 32'h8);
        end
        issue(32'hC, 2'd0, 1'b1, 32'h0000_0055, rd, er, c);
        issue(32'hC + 32'd3, 2'd0, 1'b1, 32'h0000_0066, rd, er, c);
        issue(32'hC, 2'd2, 1'b0, 0, rd, er, c);
        exp = init_word(3);
        exp[7:0] = 8'h55; exp[31:24] = 8'h66;
        chk(rd == exp && !er, "R1", rd, exp);
    endtask

    task automatic t_half_writes;
        logic [31:0] rd, exp; logic er; int c;
        issue(32'h10 + 32'd2, 2'd1, 1'b1, 32'h0000_BEEF, rd, er, c);
        chk(s_strb == 4'b1100, "R2", 32'(s_strb), 32'hC);
        chk(s_wdata[31:16] == 16'hBEEF, "R2", 32'(s_wdata[31:16]), 32'hBEEF);
        issue(32'h14, 2'd1, 1'b1, 32'h0000_1234, rd, er, c);
        chk(s_strb == 4'b0011, "R2", 32'(s_strb), 32'h3);
        issue(32'h10, 2'd2, 1'b0, 0, rd, er, c);
        exp = {16'hBEEF, init_word(4)[15:0]};
        chk(rd == exp, "R2", rd, exp);
    endtask

    task automatic t_word_write;
        logic [31:0] rd; logic er; int c;
        issue(32'h18, 2'd2, 1'b1, 32'hCAFE_F00D, rd, er, c);
        chk(s_strb == 4'hF && s_wdata == 32'hCAFE_F00D, "R3", s_wdata, 32'hCAFE_F00D);
        chk(c == 2, "R5", 32'(c), 2);
        issue(32'h18, 2'd2, 1'b0, 0, rd, er, c);
        chk(rd == 32'hCAFE_F00D, "R3", rd, 32'hCAFE_F00D);
    endtask

    task automatic t_reads;
        logic [31:0] rd, w; logic er; int c;
        w = init_word(7);
        issue(32'h1C + 32'd2, 2'd0, 1'b0, 32'hFFFF_FFFF, rd, er, c);
        chk(rd == {24'h0, w[23:16]}, "R7", rd, {24'h0, w[23:16]});
        chk(s_strb == 4'h0 && s_wr == 1'b0, "R7", {27'b0, s_wr, s_strb}, 0);
        issue(32'h1C + 32'd2, 2'd1, 1'b0, 0, rd, er, c);
        chk(rd == {16'h0, w[31:16]}, "R7", rd, {16'h0, w[31:16]});
        issue(32'h1C + 32'd1, 2'd0, 1'b0, 0, rd, er, c);
        chk(rd == {24'h0, w[15:8]}, "R7", rd, {24'h0, w[15:8]});
    endtask

    task automatic t_misaligned;
        logic [31:0] rd; logic er; int c, s0;
        s0 = setups;
        issue(32'h20 + 32'd1, 2'd1, 1'b1, 32'h1111, rd, er, c);
        chk(er && c == 0, "R4", {31'b0, er}, 1);
        issue(32'h20 + 32'd2, 2'd2, 1'b1, 32'h2222, rd, er, c);
        chk(er && c == 0, "R4", {31'b0, er}, 1);
        issue(32'h20, 2'd3, 1'b0, 0, rd, er, c);
        chk(er && c == 0, "R4", 32'(c), 0);
        repeat (2) @(negedge clk);
        chk(setups == s0, "R4", 32'(setups), 32'(s0));
        issue(32'h20, 2'd2, 1'b0, 0, rd, er, c);
        chk(rd == init_word(8) && !er, "R4", rd, init_word(8));
    endtask

    task automatic t_wait_states;
        logic [31:0] rd; logic er; int c, hb;
        hb = hold_bad;
        wait_n = 3;
        issue(32'h24 + 32'd1, 2'd0, 1'b1, 32'h0000_0077, rd, er, c);
        chk(c == 5, "R6", 32'(c), 5);
        chk(last_acc == 4, "R6", 32'(last_acc), 4);
        chk(hold_bad == hb, "R6", 32'(hold_bad), 32'(hb));
        issue(32'h24, 2'd2, 1'b0, 0, rd, er, c);
        chk(rd == {init_word(9)[31:16], 8'h77, init_word(9)[7:0]}, "R6", rd,
            {init_word(9)[31:16], 8'h77, init_word(9)[7:0]});
        wait_n = 0;
    endtask

    task automatic t_slverr;
        logic [31:0] rd; logic er; int c;
        issue(32'h3C, 2'd2, 1'b1, 32'h1, rd, er, c);
        chk(er == 1, "R8", {31'b0, er}, 1);
        issue(32'h38, 2'd2, 1'b1, 32'h1, rd, er, c);
        chk(er == 0, "R8", {31'b0, er}, 0);
        @(negedge clk); #1;
        chk(rsp_valid == 0, "R8", {31'b0, rsp_valid}, 0);
    endtask

    task automatic t_back_to_back;
        logic [31:0] rd; int gap = 0, s0; bit got_a = 0, got_b = 0;
        s0 = setups;
        @(negedge clk);
        req_addr = 32'h2C; req_size = 2'd2; req_write = 1; req_wdata = 32'h1111_2222; req_valid = 1;
        @(negedge clk);
        req_write = 0; req_wdata = 0;
        while (!got_a) begin
            #1;
            if (!psel) gap++;
            if (rsp_valid) begin
                got_a = 1;
                chk(req_ready == 1, "R9", {31'b0, req_ready}, 1);
            end else begin
                chk(req_ready == 0, "R9", {31'b0, req_ready}, 0);
            end
            @(negedge clk);
        end
        req_valid = 0;
        while (!got_b) begin
            #1;
            if (!psel) gap++;
            if (rsp_valid) begin got_b = 1; rd = rsp_rdata; end
            @(negedge clk);
        end
        chk(gap == 0, "R9", 32'(gap), 0);
        chk(setups - s0 == 2, "R9", 32'(setups - s0), 2);
        chk(rd == 32'h1111_2222, "R9", rd, 32'h1111_2222);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = init_word(i);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        t_reset();
        t_byte_writes();
        t_half_writes();
        t_word_write();
        t_reads();
        t_misaligned();
        t_wait_states();
        t_slverr();
        t_back_to_back();
        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule